// File: doc/BRIEF.md
# Color correction matrix engine

The engine sits in a pixel pipeline and multiplies every incoming RGB pixel by a programmable 3x3 matrix. Each of the nine coefficients is a signed fixed-point number. Each result channel is rounded and then clamped to the 10-bit pixel range. Pixels enter and leave through valid/ready handshakes. A register port gives software control of an on/off bit, a mode word, the frame size and the nine coefficients.

The engine counts accepted pixels against the programmed width and height, and marks the last pixel of every line and of every frame on the output. The matrix, the mode and the size in force for a frame are captured when that frame's first pixel is accepted. Register writes made during a frame therefore only take effect from the next frame. When the mode word asks for relay, or the matrix engine is not enabled, pixels pass through unchanged with the same two-cycle latency as the active path.

Top module: `ccm_engine`

## Requirements
- R1: Bit 0 of the register at offset 0x00 turns the engine on. While it reads 0, `in_ready` is low and no pixel is accepted. After reset it is 0.
- R2: In the register at offset 0x20, bit 0 requests relay and bit 1 enables the matrix. The matrix is applied only when bit 1 is 1 and bit 0 is 0. Otherwise `out_rgb` equals the accepted `in_rgb`. Bits 2 and 3 are stored and read back but change no output.
- R3: The register at offset 0x30 holds the frame height in bits 31:16 and the width in bits 15:0, both nonzero. `out_eol` is high on the last pixel of each line. `out_eof` is high only on the last pixel of the frame, together with `out_eol`.
- R4: Registers at offsets 0x80, 0x84, 0x88 and 0x8C each carry coefficient 2k in bits 27:16 and coefficient 2k+1 in bits 11:0, for k = 0..3. Offset 0x90 carries coefficient 8 in bits 27:16, and its other bits are discarded.
- R5: A coefficient is 12-bit sign-magnitude: bit 11 is the sign and bits 10:0 are the magnitude with 10 fraction bits. 0x400 is unity gain and 0x7FF is the largest gain.
- R6: Pixels pack red in bits 29:20, green in 19:10 and blue in 9:0, each 10 bits unsigned. Output red uses coefficients 0,1,2, green uses 3,4,5 and blue uses 6,7,8, applied in turn to input red, green and blue.
- R7: Each channel result is the exact sum of its three products plus 512, shifted right by 10 and clamped to 0..1023.
- R8: The coefficients, mode and size used for a frame are the register values at the moment that frame's first pixel is accepted. A write made during a frame does not alter that frame.
- R9: While `out_valid` is high and `out_ready` is low, the output pixel and its flags hold steady. Every accepted pixel leaves exactly once, in order.
- R10: With `out_ready` high, a pixel accepted at clock edge n is presented with `out_valid` high after edge n+2.
- R11: `reg_rdata` shows, without a clock, the stored value of the register at `reg_addr`. Unused field bits read 0, and addresses that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Engine accepts the input pixel |
| in_rgb | input | 30 | Input pixel {R,G,B} |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_rgb | output | 30 | Output pixel {R,G,B} |
| out_eol | output | 1 | Last pixel of a line |
| out_eof | output | 1 | Last pixel of a frame |

## Verification
A coefficient or mode write can land in the same cycle as a pixel acceptance. The most telling case is the cycle in which the first pixel of a new frame is taken, while pixels of the previous frame are still stalled in the pipeline by downstream backpressure. The bench provokes this by writing the matrix and the mode in the middle of frames, under randomly gated valid and ready. Its behavioural model latches the matrix only on a first-pixel acceptance and applies the write only after that cycle's acceptance. Every output beat is then compared against the queued expectation, so any mixing of matrices within a frame, and any dropped or repeated pixel, is caught.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    localparam int CH_W     = 10;
    localparam int COEF_W   = 12;
    localparam int FRAC_W   = 10;
    localparam int NCOEF    = 9;
    localparam int NPAIR    = NCOEF / 2;
    localparam int DIM_W    = 16;
    localparam int REG_W    = 32;
    localparam int CFG_W    = 4;
    localparam int PROD_W   = COEF_W + CH_W;
    localparam int SUM_W    = PROD_W + 2;
    localparam int HALF_LSB = 1 << (FRAC_W - 1);

    localparam int OFF_ENABLE = 'h00;
    localparam int OFF_CFG    = 'h20;
    localparam int OFF_SIZE   = 'h30;
    localparam int OFF_COEF   = 'h80;

    typedef logic [COEF_W-1:0]        coef_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic src_clip;
        logic gamma_off;
        logic engine;
        logic relay;
    } cfg_t;

    typedef struct packed {
        coef_t [NCOEF-1:0] k;
        logic              active;
        logic [DIM_W-1:0]  w;
        logic [DIM_W-1:0]  h;
    } frame_set_t;

    function automatic prod_t sm_mul(coef_t c, logic [CH_W-1:0] p);
        logic [PROD_W-2:0] mag;
        mag = (PROD_W-1)'(c[COEF_W-2:0]) * (PROD_W-1)'(p);
        return c[COEF_W-1] ? -prod_t'({1'b0, mag}) : prod_t'({1'b0, mag});
    endfunction

    function automatic logic [CH_W-1:0] round_sat(sum_t s);
        sum_t t;
        t = s + sum_t'(HALF_LSB);
        if (t[SUM_W-1])
            return '0;
        if (|t[SUM_W-2:FRAC_W+CH_W])
            return '1;
        return t[FRAC_W +: CH_W];
    endfunction

endpackage

// File: rtl/ccm_regs.sv
module ccm_regs
    import ccm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              at_start,
    input  logic              frame_start,
    output logic              en,
    output frame_set_t        eff
);

    logic              en_q;
    cfg_t              cfg_q;
    logic [DIM_W-1:0]  w_q, h_q;
    coef_t [NCOEF-1:0] coef_q;
    frame_set_t        live, shadow_q;
    logic              unused_bits;

    assign unused_bits = ^{wdata[31:28], wdata[15:12]};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            cfg_q  <= '0;
            w_q    <= '0;
            h_q    <= '0;
            coef_q <= '0;
        end else if (wr) begin
            if (addr == ADDR_W'(OFF_ENABLE))
                en_q <= wdata[0];
            if (addr == ADDR_W'(OFF_CFG))
                cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
            if (addr == ADDR_W'(OFF_SIZE)) begin
                h_q <= wdata[2*DIM_W-1:DIM_W];
                w_q <= wdata[DIM_W-1:0];
            end
            for (int p = 0; p < NPAIR; p++) begin
                if (addr == ADDR_W'(OFF_COEF + 4 * p)) begin
                    coef_q[2*p]   <= wdata[16 +: COEF_W];
                    coef_q[2*p+1] <= wdata[0 +: COEF_W];
                end
            end
            if (addr == ADDR_W'(OFF_COEF + 4 * NPAIR))
                coef_q[NCOEF-1] <= wdata[16 +: COEF_W];
        end
    end

    always_comb begin
        live.k      = coef_q;
        live.active = cfg_q.engine & ~cfg_q.relay;
        live.w      = w_q;
        live.h      = h_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            shadow_q <= '0;
        else if (frame_start)
            shadow_q <= live;
    end

    assign eff = at_start ? live : shadow_q;
    assign en  = en_q;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_ENABLE))
            rdata[0] = en_q;
        if (addr == ADDR_W'(OFF_CFG))
            rdata[CFG_W-1:0] = cfg_q;
        if (addr == ADDR_W'(OFF_SIZE))
            rdata = {h_q, w_q};
        for (int p = 0; p < NPAIR; p++) begin
            if (addr == ADDR_W'(OFF_COEF + 4 * p)) begin
                rdata[16 +: COEF_W] = coef_q[2*p];
                rdata[0 +: COEF_W]  = coef_q[2*p+1];
            end
        end
        if (addr == ADDR_W'(OFF_COEF + 4 * NPAIR))
            rdata[16 +: COEF_W] = coef_q[NCOEF-1];
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !at_start |=> $stable(shadow_q)); // R8

endmodule

// File: rtl/ccm_pos.sv
module ccm_pos
    import ccm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [DIM_W-1:0] w,
    input  logic [DIM_W-1:0] h,
    output logic             at_start,
    output logic             eol,
    output logic             eof
);

    logic [DIM_W-1:0] x_q, y_q;

    assign at_start = (x_q == '0) && (y_q == '0);
    assign eol      = (x_q == w - 1'b1);
    assign eof      = eol && (y_q == h - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= '0;
            y_q <= '0;
        end else if (accept) begin
            if (eol) begin
                x_q <= '0;
                y_q <= eof ? '0 : y_q + 1'b1;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    AST_X_BOUND: assert property (@(posedge clk) disable iff (rst)
        (w != '0) |-> (x_q < w)); // R3

endmodule

// File: rtl/ccm_datapath.sv
module ccm_datapath
    import ccm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  rgb_t              pix,
    input  coef_t [NCOEF-1:0] k,
    input  logic              active,
    input  logic              eol,
    input  logic              eof,
    input  logic              out_ready,
    output logic              move,
    output logic              out_valid,
    output rgb_t              out_pix,
    output logic              out_eol,
    output logic              out_eof
);

    logic [CH_W-1:0] ch_in [3];
    prod_t           prod_d [NCOEF];
    prod_t           prod_q [NCOEF];
    logic [CH_W-1:0] res [3];
    rgb_t            pass_q;
    logic            v1_q, act_q, eol1_q, eof1_q;

    assign ch_in[0] = pix.r;
    assign ch_in[1] = pix.g;
    assign ch_in[2] = pix.b;

    for (genvar i = 0; i < NCOEF; i++) begin : g_mul
        assign prod_d[i] = sm_mul(k[i], ch_in[i % 3]);
    end

    for (genvar r = 0; r < 3; r++) begin : g_row
        sum_t row_sum;
        assign row_sum = sum_t'(prod_q[3*r]) + sum_t'(prod_q[3*r+1])
                       + sum_t'(prod_q[3*r+2]);
        assign res[r] = round_sat(row_sum);
    end

    assign move = out_ready | ~out_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q      <= 1'b0;
            out_valid <= 1'b0;
        end else if (move) begin
            v1_q      <= accept;
            out_valid <= v1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (move) begin
            for (int i = 0; i < NCOEF; i++)
                prod_q[i] <= prod_d[i];
            pass_q  <= pix;
            act_q   <= active;
            eol1_q  <= eol;
            eof1_q  <= eof;
            out_pix <= act_q ? rgb_t'({res[0], res[1], res[2]}) : pass_q;
            out_eol <= eol1_q;
            out_eof <= eof1_q;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pix)
                                    && $stable(out_eol) && $stable(out_eof)); // R9

endmodule

// File: rtl/ccm_engine.sv
module ccm_engine
    import ccm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [3*CH_W-1:0] in_rgb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [3*CH_W-1:0] out_rgb,
    output logic              out_eol,
    output logic              out_eof
);

    logic       en, move, accept, at_start, frame_start, eol, eof;
    frame_set_t eff;
    rgb_t       out_pix;

    assign in_ready    = en & move;
    assign accept      = in_valid & in_ready;
    assign frame_start = accept & at_start;

    ccm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .at_start   (at_start),
        .frame_start(frame_start),
        .en         (en),
        .eff        (eff)
    );

    ccm_pos u_pos (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .w       (eff.w),
        .h       (eff.h),
        .at_start(at_start),
        .eol     (eol),
        .eof     (eof)
    );

    ccm_datapath u_dp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .pix      (rgb_t'(in_rgb)),
        .k        (eff.k),
        .active   (eff.active),
        .eol      (eol),
        .eof      (eof),
        .out_ready(out_ready),
        .move     (move),
        .out_valid(out_valid),
        .out_pix  (out_pix),
        .out_eol  (out_eol),
        .out_eof  (out_eof)
    );

    assign out_rgb = out_pix;

    AST_EOF_WITH_EOL: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_eof |-> out_eol); // R3

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $past(accept, 2) && $past(out_ready) |-> out_valid); // R10

endmodule

// File: tb/sim_ccm_engine.sv
module sim_ccm_engine;

    localparam int CLK_NS = 10;
    localparam int WD_CYC = 20000;

    logic        clk = 0, rst = 1;
    logic        reg_wr = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        in_valid = 0, in_ready;
    logic [29:0] in_rgb = 0;
    logic        out_valid, out_ready = 0;
    logic [29:0] out_rgb;
    logic        out_eol, out_eof;

    int checks = 0, errors = 0, cyc = 0;
    bit acc, obs_ov;

    // behavioural model state
    bit          m_en;
    logic [3:0]  m_cfg;
    int          m_w, m_h, s_w, s_h, mx, my;
    logic [11:0] m_coef [9];
    logic [11:0] s_coef [9];
    bit          s_act;
    logic [31:0] exp_q [$];

    always #(CLK_NS/2) clk = ~clk;

    ccm_engine u0 (.*);

    function automatic int smv(logic [11:0] c); // R5 sign-magnitude
        return c[11] ? -int'(c[10:0]) : int'(c[10:0]);
    endfunction

    function automatic logic [9:0] sat(int s); // R7 round and clamp
        int t;
        t = s + 512;
        if (t < 0) return 10'd0;
        t = t / 1024;
        if (t > 1023) t = 1023;
        return t[9:0];
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic model_accept(logic [29:0] p);
        int ch [3];
        logic [29:0] o;
        bit eol, eof;
        if (mx == 0 && my == 0) begin // R8 capture at frame start
            s_coef = m_coef;
            s_act  = m_cfg[1] && !m_cfg[0];
            s_w    = m_w;
            s_h    = m_h;
        end
        ch[0] = int'(p[29:20]); ch[1] = int'(p[19:10]); ch[2] = int'(p[9:0]);
        o = p;
        if (s_act) // R6 row-major rows
            for (int r = 0; r < 3; r++)
                o[29-10*r -: 10] = sat(smv(s_coef[3*r]) * ch[0]
                                     + smv(s_coef[3*r+1]) * ch[1]
                                     + smv(s_coef[3*r+2]) * ch[2]);
        eol = (mx == s_w - 1);
        eof = eol && (my == s_h - 1);
        if (eol) begin mx = 0; my = eof ? 0 : my + 1; end
        else mx = mx + 1;
        exp_q.push_back({eof, eol, o});
    endtask

    task automatic model_write(logic [7:0] a, logic [31:0] d); // R4 layout
        case (a)
            8'h00: m_en  = d[0];
            8'h20: m_cfg = d[3:0];
            8'h30: begin m_h = int'(d[31:16]); m_w = int'(d[15:0]); end
            8'h80, 8'h84, 8'h88, 8'h8C: begin
                m_coef[(a - 8'h80) / 2]     = d[27:16];
                m_coef[(a - 8'h80) / 2 + 1] = d[11:0];
            end
            8'h90: m_coef[8] = d[27:16];
            default: ;
        endcase
    endtask

    task automatic tick();
        logic [31:0] e, got;
        #1;
        cyc++;
        if (cyc > WD_CYC) begin
            errors++;
            $display("FAIL watchdog R9 actual cycles %0d expected below %0d", cyc, WD_CYC);
            summary();
            $finish;
        end
        obs_ov = out_valid;
        acc    = 0;
        if (!m_en) begin // R1
            checks++;
            if (in_ready !== 1'b0) begin
                errors++;
                $display("FAIL R1 in_ready actual %b expected 0", in_ready);
            end
        end
        if (out_valid && out_ready) begin // R3 R6 R7 R9
            checks++;
            got = {out_eof, out_eol, out_rgb};
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 extra pixel actual %h expected none", got);
            end else begin
                e = exp_q.pop_front();
                if (got !== e) begin
                    errors++;
                    $display("FAIL R3/R6/R7 pixel actual %h expected %h", got, e);
                end
            end
        end
        if (in_valid && in_ready) begin
            acc = 1;
            model_accept(in_rgb);
        end
        if (reg_wr) model_write(reg_addr, reg_wdata);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        in_valid = 0; reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read %h actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic run(int n, int vp, int rp);
        int sent = 0;
        bit have = 0;
        logic [29:0] pix = 0;
        while (sent < n) begin
            if (!have) begin pix = 30'($urandom); have = 1; end
            in_rgb    = pix;
            in_valid  = ($urandom_range(99) < vp);
            out_ready = ($urandom_range(99) < rp);
            tick();
            if (acc) begin have = 0; sent++; end
        end
        in_valid = 0;
    endtask

    task automatic send1(logic [29:0] p);
        in_rgb = p; in_valid = 1; out_ready = 1;
        do tick(); while (!acc);
        in_valid = 0;
    endtask

    task automatic drain();
        in_valid = 0; out_ready = 1;
        while (exp_q.size() != 0) tick();
        tick(); tick();
    endtask

    task automatic chk(bit cond, string msg, int act, int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", msg, act, exp);
        end
    endtask

    initial begin
        m_en = 0; m_cfg = 0; m_w = 0; m_h = 0; mx = 0; my = 0;
        s_w = 0; s_h = 0; s_act = 0;
        for (int i = 0; i < 9; i++) begin m_coef[i] = 0; s_coef[i] = 0; end
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        chk(in_ready === 1'b0, "R1 reset in_ready", int'(in_ready), 0);
        rst = 0;
        @(negedge clk);
        rd(8'h00, 32'h0, "R1");
        rd(8'h30, 32'h0, "R11");

        // setup: 4x3 frame, engine on, identity matrix
        wr(8'h30, 32'h0003_0004);
        wr(8'h20, 32'h0000_0002);
        wr(8'h80, 32'hF400_F000);
        wr(8'h84, 32'h0000_0000);
        wr(8'h88, 32'h0400_0000);
        wr(8'h8C, 32'h0000_0000);
        wr(8'h90, 32'h0400_ABCD);
        wr(8'h00, 32'h0000_0001);
        rd(8'h30, 32'h0003_0004, "R3");
        rd(8'h80, 32'h0400_0000, "R4");
        rd(8'h90, 32'h0400_0000, "R4");
        rd(8'h44, 32'h0, "R11");
        rd(8'h00, 32'h1, "R1");

        run(24, 100, 100);   // R6 identity over two frames
        drain();

        // latency probe on an empty pipe: R10
        send1(30'h3FF_FFFFF);
        tick(); chk(obs_ov == 0, "R10 early out_valid", int'(obs_ov), 0);
        tick(); chk(obs_ov == 1, "R10 out_valid at n+2", int'(obs_ov), 1);
        drain();
        run(11, 100, 100);   // finish the frame
        drain();

        // mixed matrix with clamps: R5 R7
        wr(8'h80, 32'h07FF_0200);
        wr(8'h84, 32'h0900_0C00);
        wr(8'h88, 32'h0400_0000);
        wr(8'h8C, 32'h0155_0155);
        wr(8'h90, 32'h0155_0000);
        rd(8'h84, 32'h0900_0C00, "R4");
        send1({10'd1023, 10'd1023, 10'd1023});
        send1({10'd0, 10'd1023, 10'd0});
        send1({10'd1023, 10'd0, 10'd0});
        send1({10'd0, 10'd0, 10'd0});
        run(8, 100, 100);
        drain();

        // backpressure: R9
        run(36, 70, 50);
        drain();

        // mid-frame writes: R8
        run(5, 80, 70);
        wr(8'h80, 32'h0400_0000);
        wr(8'h20, 32'h0000_0001);
        run(7, 80, 70);
        run(12, 80, 70);
        drain();

        // mode bits: R2
        wr(8'h20, 32'h0000_000E);
        rd(8'h20, 32'h0000_000E, "R2");
        run(12, 90, 60);
        wr(8'h20, 32'h0000_000F);
        run(12, 90, 60);
        wr(8'h20, 32'h0000_0000);
        run(12, 90, 60);
        wr(8'h20, 32'h0000_0002);
        drain();

        // disable mid-frame: R1
        run(3, 100, 100);
        wr(8'h00, 32'h0);
        in_rgb = 30'h1234567; in_valid = 1; out_ready = 1;
        repeat (5) tick();
        in_valid = 0;
        wr(8'h00, 32'h1);
        run(9, 100, 100);
        drain();

        chk(exp_q.size() == 0, "R9 pixels outstanding", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule